// File: doc/BRIEF.md
# Trellis State Metric Recursion Unit

This unit updates the eight state metrics of a rate-1/2 recursive systematic convolutional code (feedback polynomial 13 octal, feedforward polynomial 15 octal). It handles one trellis section per enabled clock cycle. It is the add-compare-select core of a log-domain soft-input soft-output decoder. Each cycle it takes a signed systematic soft value and a signed parity soft value. For every state it forms two candidate paths, each being an old metric plus a branch metric. It merges the two candidates with the Jacobian logarithm (max*), and the correction term of max* can be selected at run time.

The same datapath runs in either direction. In the forward direction each state's metric is built from its two predecessors. In the backward direction it is built from its two successors. After every section all eight results are made relative to state 0 and saturated to the metric width. The metrics therefore never overflow, and a state that cannot be reached stays pinned at the most negative code.

A decoder pulses `init` at the start of a sweep, at the first section going forward or at the terminal section going backward. It then pulses `step` once per trellis section. It reads `metrics` one cycle after each accepted step.

Top module: `smr_unit`

## Requirements
- R1: After reset, `metrics` shows state 0 at 0 and states 1..7 at the most negative metric code (-2^(MW-1)), and `valid` is 0.
- R2: A cycle with `init` high loads the R1 metric values whatever `dir`, `step` or the soft inputs are. `init` wins over `step`, and `valid` is 0 in the following cycle.
- R3: Trellis: state s = {s2,s1,s0}. Input bit u gives feedback a = u^s1^s0, parity z = a^s2^s0 and next state {a,s2,s1}. The branch metric is u·sys + z·par. With `dir`=0 and `mode`=2'b00, a step sets each state's new value to the maximum over its two predecessors of (old metric + branch metric).
- R4: With `mode`=2'b01, max* adds CONST_VAL to the larger candidate when the absolute difference of the two candidates is below CONST_THR. Otherwise it adds nothing.
- R5: With `mode`=2'b10, max* adds max(0, LIN_A − (|difference| >> LIN_SHIFT)) to the larger candidate.
- R6: With `dir`=1, a step takes each state's two successors (u=0 and u=1) as candidates. Each candidate is the successor's metric plus the branch metric of the transition leaving the state. The same mode rules apply.
- R7: After each step the unnormalized results are reduced by the unnormalized state-0 result and saturated to [-2^(MW-1), 2^(MW-1)-1]. The state-0 output is therefore 0.
- R8: A cycle with both `step` and `init` low leaves `metrics` unchanged.
- R9: `valid` is 1 in exactly the cycle after a cycle with `step` high and `init` low, and 0 otherwise.
- R10: `mode`=2'b11 behaves as 2'b00 (no correction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Load the starting metrics |
| step | input | 1 | Process one trellis section |
| dir | input | 1 | 0 forward, 1 backward |
| mode | input | 2 | max* correction select |
| sys_in | input | BW | Signed systematic soft value |
| par_in | input | BW | Signed parity soft value |
| metrics | output | 8*MW | Normalized metrics, state k at bits [k*MW +: MW] |
| valid | output | 1 | Metrics updated by the previous step |

## Verification
The hardest behaviour to reach from the ports is a run where states sit on the saturated floor and later climb off it. The floor value must survive the normalization subtraction unchanged, and real paths must still win against it. The bench reaches this by re-initializing every few dozen sections during a full sweep of every systematic/parity pair. Each restart begins with seven states at the floor. The following sections reproduce the climb-off for every input pair, direction and correction mode, and every section is compared with an arithmetic model.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'b00,
    CORR_CONST = 2'b01,
    CORR_LIN   = 2'b10,
    CORR_RSVD  = 2'b11
  } corr_mode_e;

  // recursive encoder step: feedback taps 13 octal, state {s2,s1,s0}
  function automatic logic [2:0] succ_state(input logic [2:0] s, input logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return {a, s[2], s[1]};
  endfunction

  // feedforward taps 15 octal
  function automatic logic parity_bit(input logic [2:0] s, input logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return a ^ s[2] ^ s[0];
  endfunction

endpackage

// File: rtl/smr_maxstar.sv
module smr_maxstar
  import smr_pkg::*;
#(
  parameter int WW        = 14,
  parameter int CONST_VAL = 2,
  parameter int CONST_THR = 4,
  parameter int LIN_A     = 3,
  parameter int LIN_SHIFT = 2
) (
  input  logic signed [WW-1:0] x_i,
  input  logic signed [WW-1:0] y_i,
  input  corr_mode_e           mode_i,
  output logic signed [WW-1:0] z_o
);

  localparam int DW = WW + 1;

  logic signed [DW-1:0] diff;
  logic        [DW-1:0] mag;
  logic signed [WW-1:0] larger;
  logic signed [DW-1:0] lin_raw;
  logic signed [WW-1:0] corr;

  always_comb begin
    diff    = DW'(x_i) - DW'(y_i);
    mag     = diff[DW-1] ? DW'(-diff) : DW'(diff);
    larger  = diff[DW-1] ? y_i : x_i;
    lin_raw = DW'(LIN_A) - $signed(mag >> LIN_SHIFT);
    unique case (mode_i)
      CORR_CONST: corr = (mag < DW'(CONST_THR)) ? WW'(CONST_VAL) : '0;
      CORR_LIN:   corr = (lin_raw > 0) ? WW'(lin_raw) : '0;
      default:    corr = '0;
    endcase
    z_o = larger + corr;
  end

endmodule

// File: rtl/smr_acs.sv
module smr_acs
  import smr_pkg::*;
#(
  parameter int MW        = 12,
  parameter int WW        = 14,
  parameter int CONST_VAL = 2,
  parameter int CONST_THR = 4,
  parameter int LIN_A     = 3,
  parameter int LIN_SHIFT = 2
) (
  input  logic signed [MW-1:0] m0_i,
  input  logic signed [MW-1:0] m1_i,
  input  logic signed [WW-1:0] bm0_i,
  input  logic signed [WW-1:0] bm1_i,
  input  corr_mode_e           mode_i,
  output logic signed [WW-1:0] z_o
);

  logic signed [WW-1:0] cand0, cand1;

  always_comb begin
    cand0 = $signed({{(WW-MW){m0_i[MW-1]}}, m0_i}) + bm0_i;
    cand1 = $signed({{(WW-MW){m1_i[MW-1]}}, m1_i}) + bm1_i;
  end

  smr_maxstar #(
    .WW(WW), .CONST_VAL(CONST_VAL), .CONST_THR(CONST_THR),
    .LIN_A(LIN_A), .LIN_SHIFT(LIN_SHIFT)
  ) u_mstar (
    .x_i(cand0), .y_i(cand1), .mode_i(mode_i), .z_o(z_o)
  );

endmodule

// File: rtl/smr_unit.sv
module smr_unit
  import smr_pkg::*;
#(
  parameter int BW        = 6,
  parameter int MW        = 12,
  parameter int CONST_VAL = 2,
  parameter int CONST_THR = 4,
  parameter int LIN_A     = 3,
  parameter int LIN_SHIFT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            step,
  input  logic            dir,
  input  logic [1:0]      mode,
  input  logic [BW-1:0]   sys_in,
  input  logic [BW-1:0]   par_in,
  output logic [8*MW-1:0] metrics,
  output logic            valid
);

  localparam int NS = 8;
  localparam int WW = MW + 2;
  localparam logic signed [WW-1:0] SMAX = WW'((1 << (MW - 1)) - 1);
  localparam logic signed [WW-1:0] SMIN = -SMAX - WW'(1);
  localparam logic signed [MW-1:0] FLOOR = MW'(SMIN);

  corr_mode_e mode_e;
  logic signed [MW-1:0] met_q [NS];
  logic signed [MW-1:0] met_d [NS];
  logic signed [WW-1:0] raw   [NS];
  logic                 valid_d;
  logic signed [WW-1:0] sys_w, par_w;

  assign mode_e = corr_mode_e'(mode);
  assign sys_w  = WW'($signed(sys_in));
  assign par_w  = WW'($signed(par_in));

  function automatic logic signed [WW-1:0] branch(input logic u, input logic z,
                                                  input logic signed [WW-1:0] sv,
                                                  input logic signed [WW-1:0] pv);
    return (u ? sv : '0) + (z ? pv : '0);
  endfunction

  function automatic logic signed [MW-1:0] clip(input logic signed [WW-1:0] v);
    if (v > SMAX) return MW'(SMAX);
    if (v < SMIN) return MW'(SMIN);
    return MW'(v);
  endfunction

  for (genvar k = 0; k < NS; k++) begin : g_state
    localparam logic [2:0] ST = 3'(k);
    logic [2:0] src0, src1;
    logic       u0, u1;
    logic signed [WW-1:0] bm0, bm1;

    always_comb begin
      if (!dir) begin
        src0 = {ST[1:0], 1'b0};
        src1 = {ST[1:0], 1'b1};
        u0   = ST[2] ^ ST[0];
        u1   = ~u0;
        bm0  = branch(u0, parity_bit(src0, u0), sys_w, par_w);
        bm1  = branch(u1, parity_bit(src1, u1), sys_w, par_w);
      end else begin
        src0 = succ_state(ST, 1'b0);
        src1 = succ_state(ST, 1'b1);
        u0   = 1'b0;
        u1   = 1'b1;
        bm0  = branch(1'b0, parity_bit(ST, 1'b0), sys_w, par_w);
        bm1  = branch(1'b1, parity_bit(ST, 1'b1), sys_w, par_w);
      end
    end

    smr_acs #(
      .MW(MW), .WW(WW), .CONST_VAL(CONST_VAL), .CONST_THR(CONST_THR),
      .LIN_A(LIN_A), .LIN_SHIFT(LIN_SHIFT)
    ) u_acs (
      .m0_i(met_q[src0]), .m1_i(met_q[src1]),
      .bm0_i(bm0), .bm1_i(bm1),
      .mode_i(mode_e), .z_o(raw[k])
    );

    assign metrics[k*MW +: MW] = met_q[k];
  end

  // next-state process
  always_comb begin
    valid_d = step & ~init;
    for (int k = 0; k < NS; k++) begin
      if (init)      met_d[k] = (k == 0) ? '0 : FLOOR;
      else if (step) met_d[k] = clip(raw[k] - raw[0]);
      else           met_d[k] = met_q[k];
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) met_q[k] <= (k == 0) ? '0 : FLOOR;
      valid <= 1'b0;
    end else begin
      valid <= valid_d;
      if (init | step) begin
        for (int k = 0; k < NS; k++) met_q[k] <= met_d[k];
      end
    end
  end

  a_r7_norm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> met_q[0] == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !init) |=> $stable(metrics));
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init) |=> valid);
  a_r2_init: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!valid && met_q[1] == FLOOR && met_q[7] == FLOOR && met_q[0] == '0));

endmodule

// File: tb/smr_unit_test.sv
module smr_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BW = 6;
  localparam int MW = 12;
  localparam int CV = 2, CT = 4, LA = 3, LS = 2;
  localparam int FLO = -(1 << (MW - 1));
  localparam int TOP = (1 << (MW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, step = 1'b0, dir = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [BW-1:0] sys_in = '0, par_in = '0;
  logic [8*MW-1:0] metrics;
  logic valid;

  int checks = 0;
  int errors = 0;
  int refm [8];

  always #2.5 clk = ~clk;

  smr_unit #(.BW(BW), .MW(MW), .CONST_VAL(CV), .CONST_THR(CT),
             .LIN_A(LA), .LIN_SHIFT(LS)) uut (
    .clk(clk), .rst_n(rst_n), .init(init), .step(step), .dir(dir),
    .mode(mode), .sys_in(sys_in), .par_in(par_in),
    .metrics(metrics), .valid(valid));

  function automatic int got(input int k);
    return int'($signed(metrics[k*MW +: MW]));
  endfunction

  function automatic int mstar(input int x, input int y, input int md);
    int d, c;
    d = (x > y) ? x - y : y - x;
    c = 0;
    if (md == 1 && d < CT) c = CV;
    if (md == 2) c = (LA - (d >> LS) > 0) ? LA - (d >> LS) : 0;
    return ((x > y) ? x : y) + c;
  endfunction

  task automatic ref_reset();
    for (int k = 0; k < 8; k++) refm[k] = (k == 0) ? 0 : FLO;
  endtask

  task automatic ref_step(input int v, input int r, input int md, input bit bwd);
    int cand [8][2];
    int cnt [8];
    int nw [8];
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 2; u++) begin
        int a, z, ns, g;
        a  = u ^ ((s >> 1) & 1) ^ (s & 1);
        z  = a ^ ((s >> 2) & 1) ^ (s & 1);
        ns = (a << 2) | (((s >> 2) & 1) << 1) | ((s >> 1) & 1);
        g  = u * v + z * r;
        if (!bwd) begin cand[ns][cnt[ns]] = refm[s] + g; cnt[ns]++; end
        else      begin cand[s][u] = refm[ns] + g; end
      end
    end
    for (int k = 0; k < 8; k++) nw[k] = mstar(cand[k][0], cand[k][1], md);
    for (int k = 0; k < 8; k++) begin
      int t;
      t = nw[k] - nw[0];
      refm[k] = (t > TOP) ? TOP : (t < FLO) ? FLO : t;
    end
  endtask

  task automatic cmp_all(input string tag);
    bit bad;
    bad = 0;
    for (int k = 0; k < 8; k++) if (got(k) != refm[k]) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s metrics got %0d %0d %0d %0d %0d %0d %0d %0d exp %0d %0d %0d %0d %0d %0d %0d %0d",
               tag, got(0), got(1), got(2), got(3), got(4), got(5), got(6), got(7),
               refm[0], refm[1], refm[2], refm[3], refm[4], refm[5], refm[6], refm[7]);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid got %0b exp %0b", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic cycle(input bit i, input bit s, input bit d, input int md,
                       input int v, input int r);
    @(negedge clk);
    init = i; step = s; dir = d; mode = 2'(md);
    sys_in = BW'(v); par_in = BW'(r);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    int n;
    repeat (3) @(posedge clk);
    #1;
    ref_reset();
    cmp_all("R1 reset metrics");
    chk_bit("R1 reset valid", valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: init overrides step after metrics moved
    cycle(0, 1, 0, 0, 20, -11);
    ref_step(20, -11, 0, 0);
    cmp_all("R3 first section");
    chk_bit("R9 valid after step", valid, 1'b1);
    cycle(1, 1, 1, 2, 31, 31);
    ref_reset();
    cmp_all("R2 init over step");
    chk_bit("R2 valid after init", valid, 1'b0);

    // R8: hold with step low and changing inputs
    cycle(0, 1, 0, 1, -7, 13);
    ref_step(-7, 13, 1, 0);
    cycle(0, 0, 1, 2, 25, -30);
    cmp_all("R8 hold");
    chk_bit("R9 valid low on idle", valid, 1'b0);

    // sweep every input pair in every mode and both directions
    for (int d = 0; d < 2; d++) begin
      for (int md = 0; md < 4; md++) begin
        if (d == 1)       tag = "R6 backward";
        else if (md == 0) tag = "R3 max-log";
        else if (md == 1) tag = "R4 constant";
        else if (md == 2) tag = "R5 linear";
        else              tag = "R10 reserved mode";
        cycle(1, 0, d[0], md, 0, 0);
        ref_reset();
        n = 0;
        for (int v = -(1 << (BW - 1)); v < (1 << (BW - 1)); v++) begin
          for (int r = -(1 << (BW - 1)); r < (1 << (BW - 1)); r++) begin
            if (n == 37) begin
              cycle(1, 0, d[0], md, 0, 0);
              ref_reset();
              n = 0;
            end
            cycle(0, 1, d[0], md, v, r);
            ref_step(v, r, md, d[0]);
            cmp_all(tag);
            n++;
            if ((v & 15) == 0 && r == 0) begin
              chk_bit("R9 valid in sweep", valid, 1'b1);
              checks++;
              if (got(0) != 0) begin
                errors++;
                $display("FAIL R7 state0 got %0d exp 0", got(0));
              end
            end
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule